// File: doc/BRIEF.md
# Back-EMF Sample-Hold Controller

This block sets the digital back-EMF readout of a stepper driver. Each motor phase supplies an unsigned coil-voltage word and a flag that is high while that phase's coil current sits at its zero crossing. The phases share a PWM sample strobe, a transparency bit and a gain-select bit. A clock in which a phase's zero flag and the strobe are both high is a sampling moment for that phase. At each sampling moment the block captures the coil word, divided by 2 or by 4. Outside the currentless window every held output keeps its value.

The transparency bit chooses how captures reach the output. In transparent mode each capture goes to the held output at once, so the readout shows the coil voltage live during the window, transients included. In deferred mode the held output keeps its previous value for the whole window. On the first clock after the zero flag drops, the output takes the last sample captured in that window. This gives a smoother signal for post-processing. For each phase the block also exposes the enables for the sample switch and the hold switch.

Top module: `bemf_sh_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every held output reads zero and no sample is valid. Both switch enables stay low until the first sampling moment.
- R2: The sample-switch enable of a phase is high in exactly those cycles where that phase's zero flag and the strobe are both high.
- R3: With transparency set (transp_i = 1), each sampling moment loads the scaled coil word into the held output at the next clock edge.
- R4: With transparency clear (transp_i = 0), the held output does not change in any cycle where the phase's zero flag is high.
- R5: With transparency clear, on the first clock edge at which the zero flag is low after being high, the held output takes the last sample captured in that window.
- R6: A currentless window with no sampling moment publishes nothing at its end, and the held output keeps its previous value.
- R7: While the zero flag is low and the window has already been closed, the held output ignores the coil word and all mode inputs in both modes.
- R8: gain_sel_i = 0 scales by a right shift of 1 (divide by 2). gain_sel_i = 1 scales by a right shift of 2 (divide by 4).
- R9: The gain is fixed at each sampling moment. A change of gain_sel_i after the last capture of a deferred window does not alter the value published at its end.
- R10: Phases are independent. Activity on one phase never changes another phase's held output.
- R11: The hold-switch enable of a phase is high in exactly the cycles whose next clock edge loads that phase's held output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| transp_i | input | 1 | 1 = transparent (live) update, 0 = deferred update |
| gain_sel_i | input | 1 | 0 = divide by 2, 1 = divide by 4 |
| strobe_i | input | 1 | PWM sample strobe shared by all phases |
| zero_i | input | NPH | Per-phase coil-current-is-zero flag |
| vcoil_i | input | NPH*W | Per-phase unsigned coil-voltage words, phase p in bits [p*W +: W] |
| held_o | output | NPH*W | Per-phase held back-EMF words, same packing |
| sample_sw_o | output | NPH | Per-phase sample-switch enable |
| hold_sw_o | output | NPH | Per-phase hold-switch enable (output load) |

## Verification
Both switch enables are combinational from the inputs and the registered state, so they are due in the same cycle as the stimulus. The bench drives on the falling clock edge and reads them one time unit later, before the rising edge. The held outputs are due one rising edge after the sampling moment in transparent mode, and one edge after the zero flag drops in deferred mode. The bench reads each of them at the falling edge that follows that rising edge. Every cycle in which a held value must stay still is also checked at a falling edge, so an early or extra load is caught in the cycle where it happens.

// File: rtl/bemf_pkg.sv
package bemf_pkg;
  typedef enum logic {
    GAIN_HALF    = 1'b0,
    GAIN_QUARTER = 1'b1
  } gain_e;
endpackage

// File: rtl/bemf_rst_sync.sv
module bemf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/bemf_scale.sv
module bemf_scale
  import bemf_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] raw_i,
  input  gain_e        gain_i,
  output logic [W-1:0] scaled_o
);
  always_comb begin
    unique case (gain_i)
      GAIN_HALF:    scaled_o = raw_i >> 1;
      GAIN_QUARTER: scaled_o = raw_i >> 2;
      default:      scaled_o = raw_i >> 1;
    endcase
  end
endmodule

// File: rtl/bemf_phase_ch.sv
module bemf_phase_ch
  import bemf_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         transp_i,
  input  gain_e        gain_i,
  input  logic         strobe_i,
  input  logic         zero_i,
  input  logic [W-1:0] vcoil_i,
  output logic [W-1:0] held_o,
  output logic         sample_sw_o,
  output logic         hold_sw_o
);
  logic [W-1:0] scaled;
  logic [W-1:0] samp_q, samp_d;
  logic [W-1:0] out_q, out_d;
  logic         vld_q, vld_d;
  logic         zero_q;
  logic         cap_en, win_end, pub_en;

  bemf_scale #(.W(W)) u_scale (
    .raw_i    (vcoil_i),
    .gain_i   (gain_i),
    .scaled_o (scaled)
  );

  always_comb begin
    cap_en  = zero_i & strobe_i;
    win_end = zero_q & ~zero_i;
    pub_en  = (cap_en & transp_i) | (win_end & ~transp_i & vld_q);
    samp_d  = samp_q;
    vld_d   = vld_q;
    out_d   = out_q;
    if (cap_en) begin
      samp_d = scaled;
      vld_d  = 1'b1;
    end else if (win_end) begin
      vld_d  = 1'b0;
    end
    if (pub_en) out_d = cap_en ? scaled : samp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      vld_q  <= 1'b0;
      out_q  <= '0;
      zero_q <= 1'b0;
    end else begin
      zero_q <= zero_i;
      if (cap_en | win_end) begin
        samp_q <= samp_d;
        vld_q  <= vld_d;
      end
      if (pub_en) out_q <= out_d;
    end
  end

  assign held_o      = out_q;
  assign sample_sw_o = cap_en;
  assign hold_sw_o   = pub_en;

  AST_SAMPLE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_sw_o |-> (zero_i && strobe_i)); // R2

  AST_TRANSP_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (transp_i && zero_i && strobe_i) |=>
      (out_q == (($past(gain_i) == GAIN_QUARTER) ? ($past(vcoil_i) >> 2)
                                                  : ($past(vcoil_i) >> 1)))); // R3

  AST_DEFER_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!transp_i && zero_i) |=> $stable(out_q)); // R4

  AST_DEFER_PUBLISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!transp_i && !zero_i && zero_q && vld_q) |=> (out_q == $past(samp_q))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zero_i && !zero_q) |=> $stable(out_q)); // R7

  AST_NO_LOAD_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_sw_o |=> $stable(held_o)); // R11
endmodule

// File: rtl/bemf_sh_ctrl.sv
module bemf_sh_ctrl
  import bemf_pkg::*;
#(
  parameter int NPH = 2,
  parameter int W   = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           transp_i,
  input  logic           gain_sel_i,
  input  logic           strobe_i,
  input  logic [NPH-1:0] zero_i,
  input  logic [NPH*W-1:0] vcoil_i,
  output logic [NPH*W-1:0] held_o,
  output logic [NPH-1:0] sample_sw_o,
  output logic [NPH-1:0] hold_sw_o
);
  localparam int RST_STAGES = 2;

  logic  rst_n_s;
  gain_e gain;

  assign gain = gain_e'(gain_sel_i);

  bemf_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_s)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    bemf_phase_ch #(.W(W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_n_s),
      .transp_i    (transp_i),
      .gain_i      (gain),
      .strobe_i    (strobe_i),
      .zero_i      (zero_i[p]),
      .vcoil_i     (vcoil_i[p*W +: W]),
      .held_o      (held_o[p*W +: W]),
      .sample_sw_o (sample_sw_o[p]),
      .hold_sw_o   (hold_sw_o[p])
    );
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_n_s |-> (held_o == '0)); // R1

  AST_SW_QUIET_OFF_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ((sample_sw_o & ~zero_i) == '0)); // R2
endmodule

// File: tb/bemf_sh_ctrl_bench.sv
module bemf_sh_ctrl_bench;
  localparam int NPH = 2;
  localparam int W   = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             transp, gain_sel, strobe;
  logic [NPH-1:0]   zero;
  logic [NPH*W-1:0] vcoil;
  logic [NPH*W-1:0] held;
  logic [NPH-1:0]   sample_sw, hold_sw;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  bemf_sh_ctrl #(.NPH(NPH), .W(W)) u_bemf_sh_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .transp_i    (transp),
    .gain_sel_i  (gain_sel),
    .strobe_i    (strobe),
    .zero_i      (zero),
    .vcoil_i     (vcoil),
    .held_o      (held),
    .sample_sw_o (sample_sw),
    .hold_sw_o   (hold_sw)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int out_of(input int ph);
    return int'(held[ph*W +: W]);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int ph, input bit z, input bit s, input int v);
    zero[ph]          = z;
    strobe            = s;
    vcoil[ph*W +: W]  = v[W-1:0];
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; transp = 1'b0; gain_sel = 1'b0; strobe = 1'b0;
    zero = '0; vcoil = '0;
    repeat (3) @(negedge clk);
    chk("R1 held during reset", int'(held), 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 held after release", int'(held), 0);
    chk("R1 sample sw idle", int'(sample_sw), 0);
    chk("R1 hold sw idle", int'(hold_sw), 0);
  endtask

  task automatic t_transparent();
    transp = 1'b1; gain_sel = 1'b0;
    drive(0, 1'b1, 1'b1, 12'h800);
    chk("R2 sample sw on strobe", int'(sample_sw), 1);
    chk("R11 hold sw on live load", int'(hold_sw), 1);
    step();
    chk("R3 live load", out_of(0), 12'h400);
    drive(0, 1'b1, 1'b1, 12'hA00);
    step();
    chk("R3 live follows", out_of(0), 12'h500);
    drive(0, 1'b1, 1'b0, 12'hFFF);
    chk("R2 sample sw off without strobe", int'(sample_sw), 0);
    step();
    chk("R3 no strobe keeps value", out_of(0), 12'h500);
    drive(0, 1'b0, 1'b1, 12'h123);
    chk("R2 sample sw off outside window", int'(sample_sw), 0);
    step();
    drive(0, 1'b0, 1'b1, 12'hFFF);
    transp = 1'b0; gain_sel = 1'b1;
    step(); step();
    chk("R7 idle ignores coil and modes", out_of(0), 12'h500);
  endtask

  task automatic t_gain();
    transp = 1'b1; gain_sel = 1'b1;
    drive(0, 1'b1, 1'b1, 12'hFFC);
    step();
    chk("R8 divide by 4", out_of(0), 12'h3FF);
    gain_sel = 1'b0;
    drive(0, 1'b1, 1'b1, 12'hFFC);
    step();
    chk("R8 divide by 2", out_of(0), 12'h7FE);
    drive(0, 1'b0, 1'b0, 12'h000);
    step();
  endtask

  task automatic t_deferred();
    transp = 1'b0; gain_sel = 1'b0;
    drive(0, 1'b1, 1'b1, 12'h100);
    chk("R11 no hold sw in deferred window", int'(hold_sw), 0);
    step();
    chk("R4 still during window", out_of(0), 12'h7FE);
    drive(0, 1'b1, 1'b1, 12'h600);
    step();
    chk("R4 still after second capture", out_of(0), 12'h7FE);
    drive(0, 1'b1, 1'b0, 12'hFFF);
    gain_sel = 1'b1;
    step();
    chk("R4 still without strobe", out_of(0), 12'h7FE);
    drive(0, 1'b0, 1'b0, 12'hEEE);
    chk("R11 hold sw at window exit", int'(hold_sw), 1);
    step();
    chk("R5 publish last sample", out_of(0), 12'h300);
    chk("R9 gain frozen at capture", out_of(0), 12'h300);
    chk("R10 other phase untouched", out_of(1), 0);
    chk("R11 hold sw single pulse", int'(hold_sw), 0);
  endtask

  task automatic t_empty_window();
    transp = 1'b0;
    drive(0, 1'b1, 1'b0, 12'h0AA);
    repeat (3) step();
    drive(0, 1'b0, 1'b0, 12'h0AA);
    chk("R6 no hold sw for empty window", int'(hold_sw), 0);
    step();
    chk("R6 empty window keeps value", out_of(0), 12'h300);
  endtask

  task automatic t_phase1();
    transp = 1'b1; gain_sel = 1'b0;
    drive(1, 1'b1, 1'b1, 12'h246);
    chk("R10 only phase 1 samples", int'(sample_sw), 2);
    step();
    chk("R10 phase 1 live", out_of(1), 12'h123);
    chk("R10 phase 0 unaffected", out_of(0), 12'h300);
    drive(1, 1'b0, 1'b0, 12'h000);
    step();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_transparent();
    t_gain();
    t_deferred();
    t_empty_window();
    t_phase1();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule